// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive peripheral interrupt lines and produces one interrupt request per CPU. Every input passes through a synchroniser, and the synchronised level is shared by all CPUs. Each CPU owns a private bank of mask words. An input reaches a CPU only while that CPU's mask bit for it is clear, so software routes any input to any CPU by unmasking it in the bank of that CPU alone.

Software reaches the banks through a simple synchronous port that has separate read and write addresses. Mask bits never change through a read-modify-write sequence. A write-one-to-set word masks the bits it names and a write-one-to-clear word unmasks them. Two CPUs can therefore change their own bits without racing each other. The block has no priority logic and no vector register. To find the pending sources, software reads every status word.

The register access uses a small set of named word kinds, `REG_STATUS`, `REG_MSET`, `REG_MCLR` and `REG_MASK`, and a `unique case` on the kind selects the action. The block has no sequencing state machine. Its only state is the synchroniser, the mask words, the per-CPU output flops and the read data register.

Top module: `irqagg_top`

## Requirements
- R1: `NUM_IRQ` must be 64, 96, 128 or 160, which gives G = NUM_IRQ/32 groups of 32 inputs, where input i belongs to group i/32 at bit i%32. The word address of CPU c, group g and kind k is c*4*G + 4*g + k. The kinds are k=0 status (read-only), k=1 mask-set (write-only), k=2 mask-clear (write-only) and k=3 mask (read-only). An address at or above NUM_CPU*4*G is out of range.
- R2: After reset, every mask bit of every CPU reads as 1, every `cpu_irq` bit is 0 and `rd_data` is 0.
- R3: A status word returns the raw input levels of its group after a two-flop synchroniser, whatever the mask holds. A level applied before a clock edge is visible to a read issued two edges later.
- R4: Writing a mask-set word sets each mask bit written as 1 (masked) and leaves the bits written as 0 unchanged.
- R5: Writing a mask-clear word clears each mask bit written as 1 (unmasked) and leaves the bits written as 0 unchanged.
- R6: Each CPU has an independent mask bank. A write to one CPU's bank changes no other CPU's mask or output, so a single input can be routed to exactly the CPUs that unmask it.
- R7: `cpu_irq[c]` is a register that takes the OR over all inputs of (status AND NOT mask of CPU c). It changes on the edge after the status or mask change, which is three edges after an input change and one edge after a mask write.
- R8: A read of a mask word issued in the same cycle as a set or clear write to that group returns the value from before the write.
- R9: Writes to status, mask or out-of-range addresses change nothing. Reads of mask-set, mask-clear or out-of-range addresses return zero.
- R10: Read data is registered. It appears on the edge after `rd_en` and is zero on any cycle that follows a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Level interrupt inputs, high = pending |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Registered interrupt request per CPU |

## Verification
A corrupted mask bit shows up in two places. The interrupt line of its CPU is wrong one edge after the bad state forms, and a read of the mask word in the next cycle shows the wrong bit. A decode fault that sends a write to the wrong CPU or group shows in the mask word of the neighbouring bank and in a `cpu_irq` bit that rises when it should not. A synchroniser that is too short or too long moves the rise of `cpu_irq` off its third edge. The bench samples that cycle exactly.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MSET   = 2'd1,
        REG_MCLR   = 2'd2,
        REG_MASK   = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH  = 96,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[s] <= '0;
            end else begin
                stg[s] <= (s == 0) ? d_in : stg[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NGRP    = 3,
    parameter int NUM_CPU = 2,
    parameter int ADDR_W  = 5,
    localparam int CW     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int GW     = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [CW-1:0]     cpu,
    output logic [GW-1:0]     grp,
    output reg_kind_e         kind
);
    localparam logic [31:0] BANK_WORDS = 32'(4 * NGRP);
    localparam logic [31:0] ALL_WORDS  = 32'(NUM_CPU * 4 * NGRP);

    logic [31:0] a_ext;
    logic [31:0] off;

    always_comb begin
        a_ext    = 32'(addr);
        in_range = (a_ext < ALL_WORDS);
        off      = a_ext % BANK_WORDS;
        cpu      = CW'(a_ext / BANK_WORDS);
        grp      = GW'(off >> 2);
        kind     = reg_kind_e'(off[1:0]);
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int NGRP = 3,
    localparam int W   = NGRP * WORD_W,
    localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [GW-1:0]     wr_grp,
    input  reg_kind_e         wr_kind,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [W-1:0]      status,
    output logic [W-1:0]      mask,
    output logic              irq_out
);
    logic [WORD_W-1:0] mask_q [NGRP];
    logic [W-1:0]      pend;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= '1;
            end else if (wr_sel && (wr_grp == GW'(g))) begin
                unique case (wr_kind)
                    REG_MSET: mask_q[g] <= mask_q[g] | wr_data;
                    REG_MCLR: mask_q[g] <= mask_q[g] & ~wr_data;
                    default:  mask_q[g] <= mask_q[g];
                endcase
            end
        end
        assign mask[g*WORD_W +: WORD_W] = mask_q[g];

        // R4
        mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && wr_grp == GW'(g) && wr_kind == REG_MSET)
            |=> ((mask_q[g] & $past(wr_data)) == $past(wr_data)));

        // R5
        mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && wr_grp == GW'(g) && wr_kind == REG_MCLR)
            |=> ((mask_q[g] & $past(wr_data)) == '0));
    end

    assign pend = status & ~mask;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |pend;
    end

    // R2
    mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '1));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(mask));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |=> irq_out);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq_out);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_IRQ     = 96,
    parameter int NUM_CPU     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_CPU * 4 * (NUM_IRQ / 32))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int NGRP = NUM_IRQ / WORD_W;
    localparam int CW   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;

    // R1
    if (!(NUM_IRQ == 64 || NUM_IRQ == 96 || NUM_IRQ == 128 || NUM_IRQ == 160)) begin : g_bad_cfg
        $error("irqagg_top: NUM_IRQ must be 64, 96, 128 or 160");
    end

    logic [NUM_IRQ-1:0] status;
    logic [NUM_IRQ-1:0] mask_all [NUM_CPU];
    logic               wr_ok, rd_ok;
    logic [CW-1:0]      wr_cpu, rd_cpu;
    logic [GW-1:0]      wr_grp, rd_grp;
    reg_kind_e          wr_kind, rd_kind;
    logic [31:0]        rd_word;

    irqagg_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(irq_in), .q_out(status)
    );

    irqagg_decode #(.NGRP(NGRP), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_wdec (
        .addr(wr_addr), .in_range(wr_ok), .cpu(wr_cpu), .grp(wr_grp), .kind(wr_kind)
    );

    irqagg_decode #(.NGRP(NGRP), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_rdec (
        .addr(rd_addr), .in_range(rd_ok), .cpu(rd_cpu), .grp(rd_grp), .kind(rd_kind)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        irqagg_bank #(.NGRP(NGRP)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_sel  (wr_en && wr_ok && (wr_cpu == CW'(c))),
            .wr_grp  (wr_grp),
            .wr_kind (wr_kind),
            .wr_data (wr_data),
            .status  (status),
            .mask    (mask_all[c]),
            .irq_out (cpu_irq[c])
        );
    end

    always_comb begin
        rd_word = '0;
        if (rd_ok) begin
            unique case (rd_kind)
                REG_STATUS: rd_word = status[32'(rd_grp) * WORD_W +: WORD_W];
                REG_MASK:   rd_word = mask_all[rd_cpu][32'(rd_grp) * WORD_W +: WORD_W];
                default:    rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
        else            rd_data <= '0;
    end

    // R9
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (!rd_ok || rd_kind == REG_MSET || rd_kind == REG_MCLR)) |=> (rd_data == '0));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
endmodule

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 96;
    localparam int NCPU = 2;
    localparam int G    = NIRQ / 32;
    localparam int AW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq_in = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [31:0]     rd_data;
    logic [NCPU-1:0] cpu_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .SYNC_STAGES(2), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    function automatic logic [AW-1:0] adr(input int c, input int g, input int k);
        return AW'(c * 4 * G + g * 4 + k);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R2 irq after reset", 32'(cpu_irq), 32'h0);
        chk("R2 rd_data after reset", rd_data, 32'h0);
        for (int c = 0; c < NCPU; c++) begin
            for (int g = 0; g < G; g++) begin
                do_read(adr(c, g, 3), v);
                chk("R2 mask reset value", v, 32'hFFFF_FFFF);
            end
        end
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk);
        irq_in = {32'hA5A5_0001, 32'h0000_8000, 32'h1234_5678};
        @(negedge clk);
        @(negedge clk);
        do_read(adr(0, 0, 0), v); chk("R3 status g0", v, 32'h1234_5678);
        do_read(adr(0, 1, 0), v); chk("R3 status g1", v, 32'h0000_8000);
        do_read(adr(0, 2, 0), v); chk("R3 status g2", v, 32'hA5A5_0001);
        do_read(adr(1, 2, 0), v); chk("R3 status seen by cpu1", v, 32'hA5A5_0001);
        chk("R7 all masked keeps irq low", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        irq_in = '0;
        repeat (3) @(negedge clk);
        do_read(adr(0, 0, 0), v); chk("R3 status cleared", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        do_write(adr(0, 1, 2), 32'h0000_00F0);
        do_read(adr(0, 1, 3), v); chk("R5 clear unmasks", v, 32'hFFFF_FF0F);
        do_write(adr(0, 1, 1), 32'h0000_0030);
        do_read(adr(0, 1, 3), v); chk("R4 set masks", v, 32'hFFFF_FF3F);
        do_read(adr(1, 1, 3), v); chk("R6 other bank untouched", v, 32'hFFFF_FFFF);
        do_read(adr(0, 0, 3), v); chk("R6 other group untouched", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_output();
        // group 1 of cpu0: bits 6,7 unmasked, bits 4,5 masked
        @(negedge clk);
        irq_in[38] = 1'b1;
        @(negedge clk); chk("R7 no rise after 1 edge", 32'(cpu_irq), 32'h0);
        @(negedge clk); chk("R7 no rise after 2 edges", 32'(cpu_irq), 32'h0);
        @(negedge clk); chk("R7 rise on 3rd edge, cpu0 only (R6)", 32'(cpu_irq), 32'h1);
        do_write(adr(0, 1, 1), 32'h0000_0040);
        chk("R7 irq holds in write edge", 32'(cpu_irq), 32'h1);
        @(negedge clk); chk("R4 mask drops irq", 32'(cpu_irq), 32'h0);
        do_write(adr(0, 1, 2), 32'h0000_0040);
        @(negedge clk); chk("R5 unmask raises irq", 32'(cpu_irq), 32'h1);
        irq_in[38] = 1'b0;
        @(negedge clk); chk("R7 hold after 1 edge", 32'(cpu_irq), 32'h1);
        @(negedge clk); chk("R7 hold after 2 edges", 32'(cpu_irq), 32'h1);
        @(negedge clk); chk("R7 fall on 3rd edge", 32'(cpu_irq), 32'h0);
        irq_in[37] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 masked input blocked", 32'(cpu_irq), 32'h0);
        do_write(adr(1, 1, 2), 32'h0000_0020);
        @(negedge clk); chk("R6 routed to cpu1 only", 32'(cpu_irq), 32'h2);
        irq_in[37] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 cpu1 falls", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_coincide();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr(0, 2, 2); wr_data = 32'h0000_00FF;
        rd_en = 1'b1; rd_addr = adr(0, 2, 3);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        chk("R8 read returns pre-write mask", rd_data, 32'hFFFF_FFFF);
        do_read(adr(0, 2, 3), v); chk("R8 later read sees write", v, 32'hFFFF_FF00);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        do_write(adr(0, 2, 3), 32'h0000_0000);
        do_write(adr(0, 2, 0), 32'hFFFF_FFFF);
        do_read(adr(0, 2, 3), v); chk("R9 writes to read-only ignored", v, 32'hFFFF_FF00);
        do_read(adr(0, 2, 1), v); chk("R9 set word reads zero", v, 32'h0);
        do_read(adr(0, 2, 2), v); chk("R9 clear word reads zero", v, 32'h0);
        do_read(AW'(30), v);      chk("R9 out-of-range reads zero", v, 32'h0);
        do_write(AW'(29), 32'hFFFF_FFFF);
        do_read(adr(1, 0, 3), v); chk("R9 out-of-range write ignored", v, 32'hFFFF_FFFF);
        @(negedge clk); chk("R10 idle rd_data zero", rd_data, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_mask();
        t_output();
        t_coincide();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule